// File: doc/BRIEF.md
# Key-Locked Control Register Bank

This block is a bank of 32-bit system control registers on a simple memory-mapped bus. The bus carries read and write strobes, a byte address and write data. Reads return their data one cycle later. Every access decodes to an access class: read/write, read-only, write-only or unmapped. An illegal access raises an error flag for one cycle.

Writes to the bank are guarded by a lock bit, and the bank comes out of reset locked. The lock bit can only change through two dedicated write-only keyholes. One keyhole clears the lock when it receives the correct 16-bit unlock key, and the other sets it again when it receives the lock key. While the bank is locked, every other legal write is dropped.

Writing a 1 to bit 0 of the soft-reset word while the bank is unlocked produces a one-cycle system reset request. All other registers are plain storage with fixed reset values.

Top module: `sysreg_bank`

## Requirements
- R1: After reset, the lock status word (byte 0x00C) reads 1, and bus_rdata, bus_err and sys_rst_req are 0. Pin-mux words start at byte 0x400 (54 words) and reset to 0x00001601, except mux words 2 to 8 (bytes 0x408 to 0x420), which reset to 0x00000601. Plain storage words reset to 0.
- R2: A write to byte 0x004 whose low 16 bits equal 0x767B sets the lock status to 1. This happens whatever the current lock state and whatever the upper 16 bits are. Any other value leaves the lock status unchanged and raises no error.
- R3: A write to byte 0x008 whose low 16 bits equal 0xDF0D clears the lock status to 0. This happens whatever the current lock state. Any other value is ignored and raises no error.
- R4: While the bank is locked, a write to any read/write or write-only address other than the two keyholes leaves the stored value unchanged and raises bus_err in the next cycle. While the bank is unlocked, the same write is stored and bus_err stays 0.
- R5: bus_rdata and bus_err for an access appear in the cycle after the strobe. bus_rdata changes only on a read, and bus_err is 0 in any cycle that follows no illegal access.
- R6: The control word at byte 0x000 stores only bit 0 of the write data. The other bits read back as 0.
- R7: Writing a value with bit 0 = 1 to the soft-reset word (byte 0x200) while the bank is unlocked pulses sys_rst_req high for exactly the next cycle. The value is stored. The same write while the bank is locked produces no pulse.
- R8: The read-only words are lock status (0x00C), boot mode (0x300, parameter, default 1), identity (0x304, parameter, default 0x1A5E0093) and PLL status (0x308, fixed 0x3F). A read returns these values without error. A write is discarded and raises bus_err.
- R9: The write-only words are the lock keyhole (0x004), the unlock keyhole (0x008), calibration start (0x310) and refresh start (0x314). A read raises bus_err. Calibration start and refresh start store written values and return them when read. The keyholes read as 0.
- R10: A write to an unmapped byte address (for example 0x800) raises bus_err and stores nothing. A read from an unmapped address raises bus_err and returns 0.
- R11: The word index is bus_addr[11:2]. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, single cycle |
| bus_rd | input | 1 | Read strobe, single cycle |
| bus_addr | input | 12 | Byte address within the 4 KB space |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| bus_err | output | 1 | One-cycle flag for an illegal or blocked access |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench exercises several kinds of key writes:
- wrong keys, including a correct key placed in the upper half-word;
- the right key with junk in the upper bits;
- repeated lock and repeated unlock.

A design that compared all 32 bits, or that toggled the lock instead of setting or clearing it, would leave the lock status in the wrong state.

Writes are sent to read-only, write-only and unmapped words, and to plain words while the bank is locked. A decoder that mixed up the classes would either store data where it must not, or miss the error flag.

Other checks cover:
- the narrow mux reset values at the edges of their range;
- a misaligned address;
- a soft reset issued while locked;
- read-data holding across a write.

Together these catch off-by-one ranges, dropped address bits and reset pulses that escape the lock.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

    localparam int BYTE_AW = 12;
    localparam int WORD_AW = BYTE_AW - 2;
    localparam int DATA_W  = 32;
    localparam int KEY_W   = 16;
    localparam int NUM_WORDS = 1 << WORD_AW;

    typedef logic [WORD_AW-1:0] waddr_t;
    typedef logic [DATA_W-1:0]  word_t;
    typedef logic [KEY_W-1:0]   key_t;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_RO   = 2'd1,
        ACC_WO   = 2'd2,
        ACC_RW   = 2'd3
    } acc_e;

    typedef struct packed {
        acc_e acc;
        logic is_lock;
        logic is_unlock;
        logic is_status;
        logic is_ctrl;
        logic is_srst;
        logic is_boot;
        logic is_id;
        logic is_pll;
    } decode_t;

    localparam key_t LOCK_KEY   = 16'h767B;
    localparam key_t UNLOCK_KEY = 16'hDF0D;

    // word map
    localparam waddr_t W_CTRL     = waddr_t'(10'h000);
    localparam waddr_t W_LOCK     = waddr_t'(10'h001);
    localparam waddr_t W_UNLOCK   = waddr_t'(10'h002);
    localparam waddr_t W_LSTAT    = waddr_t'(10'h003);
    localparam waddr_t W_GEN_BASE = waddr_t'(10'h040);
    localparam int     GEN_WORDS  = 32;
    localparam waddr_t W_SRST     = waddr_t'(10'h080);
    localparam waddr_t W_RSTC_BASE = waddr_t'(10'h081);
    localparam int     RSTC_WORDS = 15;
    localparam waddr_t W_BOOT     = waddr_t'(10'h0C0);
    localparam waddr_t W_ID       = waddr_t'(10'h0C1);
    localparam waddr_t W_PLL      = waddr_t'(10'h0C2);
    localparam waddr_t W_CAL      = waddr_t'(10'h0C4);
    localparam waddr_t W_REF      = waddr_t'(10'h0C5);
    localparam waddr_t W_MUX_BASE = waddr_t'(10'h100);
    localparam int     MUX_WORDS  = 54;
    localparam int     MUX_NARROW_LO = 2;
    localparam int     MUX_NARROW_HI = 8;

    localparam word_t PLL_STAT_VAL   = 32'h0000_003F;
    localparam word_t MUX_RST_WIDE   = 32'h0000_1601;
    localparam word_t MUX_RST_NARROW = 32'h0000_0601;

    function automatic logic in_range(waddr_t a, waddr_t base, int n);
        return (int'(a) >= int'(base)) && (int'(a) < int'(base) + n);
    endfunction

    function automatic acc_e classify(waddr_t a);
        if (a == W_LOCK || a == W_UNLOCK || a == W_CAL || a == W_REF)
            return ACC_WO;
        if (a == W_LSTAT || a == W_BOOT || a == W_ID || a == W_PLL)
            return ACC_RO;
        if (a == W_CTRL || a == W_SRST ||
            in_range(a, W_GEN_BASE, GEN_WORDS) ||
            in_range(a, W_RSTC_BASE, RSTC_WORDS) ||
            in_range(a, W_MUX_BASE, MUX_WORDS))
            return ACC_RW;
        return ACC_NONE;
    endfunction

    function automatic word_t reset_word(waddr_t a);
        int idx;
        if (!in_range(a, W_MUX_BASE, MUX_WORDS))
            return '0;
        idx = int'(a) - int'(W_MUX_BASE);
        if (idx >= MUX_NARROW_LO && idx <= MUX_NARROW_HI)
            return MUX_RST_NARROW;
        return MUX_RST_WIDE;
    endfunction

endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
    import sysreg_pkg::*;
(
    input  waddr_t  addr,
    output decode_t dec
);

    always_comb begin
        dec           = '0;
        dec.acc       = classify(addr);
        dec.is_lock   = (addr == W_LOCK);
        dec.is_unlock = (addr == W_UNLOCK);
        dec.is_status = (addr == W_LSTAT);
        dec.is_ctrl   = (addr == W_CTRL);
        dec.is_srst   = (addr == W_SRST);
        dec.is_boot   = (addr == W_BOOT);
        dec.is_id     = (addr == W_ID);
        dec.is_pll    = (addr == W_PLL);
    end

endmodule

// File: rtl/sysreg_lock.sv
module sysreg_lock
    import sysreg_pkg::*;
#(
    parameter key_t LOCK_VAL   = LOCK_KEY,
    parameter key_t UNLOCK_VAL = UNLOCK_KEY
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic sel_lock,
    input  logic sel_unlock,
    input  key_t key,
    output logic locked
);

    logic lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b1;
        end else if (wr_en && sel_lock && key == LOCK_VAL) begin
            lock_q <= 1'b1;
        end else if (wr_en && sel_unlock && key == UNLOCK_VAL) begin
            lock_q <= 1'b0;
        end
    end

    assign locked = lock_q;

    // R2
    lock_key_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel_lock && key == LOCK_VAL) |=> locked);

    // R3
    unlock_key_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel_unlock && key == UNLOCK_VAL) |=> !locked);

    // R2 R3: nothing but a keyhole write moves the lock
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (sel_lock || sel_unlock)) |=> $stable(locked));

endmodule

// File: rtl/sysreg_store.sv
module sysreg_store
    import sysreg_pkg::*;
#(
    parameter int DEPTH = NUM_WORDS
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   we,
    input  waddr_t addr,
    input  word_t  wdata,
    output word_t  rdata
);

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= reset_word(waddr_t'(i));
            end
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
    import sysreg_pkg::*;
#(
    parameter word_t BOOT_VALUE = 32'h0000_0001,
    parameter word_t ID_VALUE   = 32'h1A5E_0093
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              sys_rst_req
);

    waddr_t  waddr;
    decode_t dec;
    logic    lock_q;
    word_t   store_rdata;
    word_t   store_wdata;
    word_t   rd_value;
    logic    key_write;
    logic    wr_bad_class;
    logic    wr_blocked;
    logic    store_we;
    logic    rd_bad;
    logic    unused_lane;

    assign waddr       = bus_addr[BYTE_AW-1:2];
    assign unused_lane = ^bus_addr[1:0];

    sysreg_decode u_decode (
        .addr (waddr),
        .dec  (dec)
    );

    sysreg_lock u_lock (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (bus_wr),
        .sel_lock   (dec.is_lock),
        .sel_unlock (dec.is_unlock),
        .key        (bus_wdata[KEY_W-1:0]),
        .locked     (lock_q)
    );

    assign key_write    = dec.is_lock || dec.is_unlock;
    assign wr_bad_class = (dec.acc == ACC_NONE) || (dec.acc == ACC_RO);
    assign wr_blocked   = !key_write && !wr_bad_class && lock_q;
    assign store_we     = bus_wr && !key_write && !wr_bad_class && !lock_q;
    assign store_wdata  = dec.is_ctrl ? {{(DATA_W-1){1'b0}}, bus_wdata[0]} : bus_wdata;
    assign rd_bad       = (dec.acc == ACC_NONE) || (dec.acc == ACC_WO);

    sysreg_store u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (store_we),
        .addr  (waddr),
        .wdata (store_wdata),
        .rdata (store_rdata)
    );

    always_comb begin
        if (dec.is_status)    rd_value = {{(DATA_W-1){1'b0}}, lock_q};
        else if (dec.is_boot) rd_value = BOOT_VALUE;
        else if (dec.is_id)   rd_value = ID_VALUE;
        else if (dec.is_pll)  rd_value = PLL_STAT_VAL;
        else                  rd_value = store_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata   <= '0;
            bus_err     <= 1'b0;
            sys_rst_req <= 1'b0;
        end else begin
            if (bus_rd) begin
                bus_rdata <= rd_value;
            end
            bus_err     <= (bus_wr && (wr_bad_class || wr_blocked)) || (bus_rd && rd_bad);
            sys_rst_req <= store_we && dec.is_srst && bus_wdata[0];
        end
    end

    // R7
    srst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |-> ($past(bus_wr) && $past(waddr) == W_SRST && !$past(lock_q)));

    // R8
    ro_write_err_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && dec.acc == ACC_RO) |=> bus_err);

    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    // R4
    locked_drop_err_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && lock_q && dec.acc == ACC_RW) |=> bus_err);

    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && dec.acc == ACC_NONE) |=> (bus_err && bus_rdata == '0));

endmodule

// File: tb/sysreg_bank_tb.sv
module sysreg_bank_tb_top;

    typedef struct packed {
        logic        rd;
        logic [11:0] addr;
        logic [31:0] wd;
        logic [31:0] exp_rd;
        logic        exp_err;
        logic        exp_rst;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 50;
    localparam logic [31:0] ID_EXP = 32'h1A5E_0093;

    // Requirements exercised: R1 R2 R3 R4 R6 R7 R8 R9 R10 R11
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h00C, 32'h0,         32'h1,         1'b0, 1'b0, 4'd1},  // R1 locked
        '{1'b1, 12'h400, 32'h0,         32'h1601,      1'b0, 1'b0, 4'd1},  // R1
        '{1'b1, 12'h408, 32'h0,         32'h0601,      1'b0, 1'b0, 4'd1},  // R1
        '{1'b1, 12'h424, 32'h0,         32'h1601,      1'b0, 1'b0, 4'd1},  // R1
        '{1'b1, 12'h420, 32'h0,         32'h0601,      1'b0, 1'b0, 4'd1},  // R1
        '{1'b0, 12'h100, 32'hAAAA5555,  32'h0,         1'b1, 1'b0, 4'd4},  // R4 locked write
        '{1'b1, 12'h100, 32'h0,         32'h0,         1'b0, 1'b0, 4'd4},  // R4
        '{1'b0, 12'h000, 32'h1,         32'h0,         1'b1, 1'b0, 4'd4},  // R4
        '{1'b0, 12'h004, 32'h1234,      32'h0,         1'b0, 1'b0, 4'd2},  // R2 wrong key
        '{1'b0, 12'h008, 32'hDF0D0000,  32'h0,         1'b0, 1'b0, 4'd3},  // R3 key in upper half
        '{1'b1, 12'h00C, 32'h0,         32'h1,         1'b0, 1'b0, 4'd3},  // R3
        '{1'b0, 12'h008, 32'hABCDDF0D,  32'h0,         1'b0, 1'b0, 4'd3},  // R3 unlock
        '{1'b1, 12'h00C, 32'h0,         32'h0,         1'b0, 1'b0, 4'd3},  // R3
        '{1'b0, 12'h100, 32'hAAAA5555,  32'h0,         1'b0, 1'b0, 4'd4},  // R4
        '{1'b1, 12'h100, 32'h0,         32'hAAAA5555,  1'b0, 1'b0, 4'd4},  // R4
        '{1'b0, 12'h000, 32'hFFFFFFFE,  32'h0,         1'b0, 1'b0, 4'd6},  // R6
        '{1'b1, 12'h000, 32'h0,         32'h0,         1'b0, 1'b0, 4'd6},  // R6
        '{1'b0, 12'h000, 32'hFFFFFFFF,  32'h0,         1'b0, 1'b0, 4'd6},  // R6
        '{1'b1, 12'h000, 32'h0,         32'h1,         1'b0, 1'b0, 4'd6},  // R6
        '{1'b0, 12'h300, 32'h123,       32'h0,         1'b1, 1'b0, 4'd8},  // R8
        '{1'b1, 12'h300, 32'h0,         32'h1,         1'b0, 1'b0, 4'd8},  // R8
        '{1'b0, 12'h304, 32'h0,         32'h0,         1'b1, 1'b0, 4'd8},  // R8
        '{1'b1, 12'h304, 32'h0,         ID_EXP,        1'b0, 1'b0, 4'd8},  // R8
        '{1'b1, 12'h308, 32'h0,         32'h3F,        1'b0, 1'b0, 4'd8},  // R8
        '{1'b0, 12'h00C, 32'h1,         32'h0,         1'b1, 1'b0, 4'd8},  // R8
        '{1'b1, 12'h00C, 32'h0,         32'h0,         1'b0, 1'b0, 4'd8},  // R8
        '{1'b0, 12'h310, 32'h55,        32'h0,         1'b0, 1'b0, 4'd9},  // R9
        '{1'b1, 12'h310, 32'h0,         32'h55,        1'b1, 1'b0, 4'd9},  // R9
        '{1'b1, 12'h004, 32'h0,         32'h0,         1'b1, 1'b0, 4'd9},  // R9
        '{1'b1, 12'h314, 32'h0,         32'h0,         1'b1, 1'b0, 4'd9},  // R9
        '{1'b0, 12'h800, 32'h77,        32'h0,         1'b1, 1'b0, 4'd10}, // R10
        '{1'b1, 12'h800, 32'h0,         32'h0,         1'b1, 1'b0, 4'd10}, // R10
        '{1'b1, 12'h401, 32'h0,         32'h1601,      1'b0, 1'b0, 4'd11}, // R11
        '{1'b0, 12'h40B, 32'hBEEF,      32'h0,         1'b0, 1'b0, 4'd11}, // R11
        '{1'b1, 12'h408, 32'h0,         32'hBEEF,      1'b0, 1'b0, 4'd11}, // R11
        '{1'b0, 12'h200, 32'h1,         32'h0,         1'b0, 1'b1, 4'd7},  // R7 pulse
        '{1'b1, 12'h200, 32'h0,         32'h1,         1'b0, 1'b0, 4'd7},  // R7 stored
        '{1'b0, 12'h200, 32'h0,         32'h0,         1'b0, 1'b0, 4'd7},  // R7
        '{1'b0, 12'h008, 32'hDF0D,      32'h0,         1'b0, 1'b0, 4'd3},  // R3 repeat unlock
        '{1'b1, 12'h00C, 32'h0,         32'h0,         1'b0, 1'b0, 4'd3},  // R3
        '{1'b0, 12'h004, 32'hFFFF767B,  32'h0,         1'b0, 1'b0, 4'd2},  // R2 lock
        '{1'b1, 12'h00C, 32'h0,         32'h1,         1'b0, 1'b0, 4'd2},  // R2
        '{1'b0, 12'h004, 32'h767B,      32'h0,         1'b0, 1'b0, 4'd2},  // R2 repeat lock
        '{1'b1, 12'h00C, 32'h0,         32'h1,         1'b0, 1'b0, 4'd2},  // R2
        '{1'b0, 12'h200, 32'h1,         32'h0,         1'b1, 1'b0, 4'd7},  // R7 locked
        '{1'b1, 12'h200, 32'h0,         32'h0,         1'b0, 1'b0, 4'd7},  // R7
        '{1'b0, 12'h104, 32'h9,         32'h0,         1'b1, 1'b0, 4'd4},  // R4
        '{1'b1, 12'h104, 32'h0,         32'h0,         1'b0, 1'b0, 4'd4},  // R4
        '{1'b0, 12'h004, 32'h1,         32'h0,         1'b0, 1'b0, 4'd2},  // R2 wrong key
        '{1'b1, 12'h00C, 32'h0,         32'h1,         1'b0, 1'b0, 4'd2}   // R2
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        sys_rst_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sysreg_bank dut_i (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bus_err     (bus_err),
        .sys_rst_req (sys_rst_req)
    );

    task automatic expect32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic rd, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_rd    = rd;
        bus_wr    = !rd;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_rd = 1'b0;
        bus_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 outputs during reset
        expect32("R1 rdata in reset", bus_rdata, 32'h0);
        expect32("R1 err in reset", {31'b0, bus_err}, 32'h0);
        expect32("R1 rst_req in reset", {31'b0, sys_rst_req}, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].rd, VECS[i].addr, VECS[i].wd);
            if (VECS[i].rd)
                expect32($sformatf("R%0d vec %0d rdata", VECS[i].req, i), bus_rdata, VECS[i].exp_rd);
            expect32($sformatf("R%0d vec %0d err", VECS[i].req, i), {31'b0, bus_err}, {31'b0, VECS[i].exp_err});
            expect32($sformatf("R%0d vec %0d rst_req", VECS[i].req, i), {31'b0, sys_rst_req}, {31'b0, VECS[i].exp_rst});
        end

        // R7 pulse lasts one cycle
        access(1'b0, 12'h008, 32'hDF0D);
        access(1'b0, 12'h200, 32'h3);
        expect32("R7 pulse high", {31'b0, sys_rst_req}, 32'h1);
        @(negedge clk);
        expect32("R7 pulse gone", {31'b0, sys_rst_req}, 32'h0);

        // R5 read data holds across writes and idle cycles
        access(1'b1, 12'h400, 32'h0);
        expect32("R5 read", bus_rdata, 32'h1601);
        access(1'b0, 12'h800, 32'hFFFF);
        expect32("R5 hold on write", bus_rdata, 32'h1601);
        expect32("R5 err on bad write", {31'b0, bus_err}, 32'h1);
        @(negedge clk);
        expect32("R5 err idle", {31'b0, bus_err}, 32'h0);
        expect32("R5 hold idle", bus_rdata, 32'h1601);

        // R1 reset in mid-run restores lock and defaults
        access(1'b0, 12'h100, 32'h12345678);
        access(1'b0, 12'h408, 32'h0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        @(negedge clk); rst = 1'b0;
        access(1'b1, 12'h00C, 32'h0);
        expect32("R1 relock after reset", bus_rdata, 32'h1);
        access(1'b1, 12'h100, 32'h0);
        expect32("R1 storage cleared", bus_rdata, 32'h0);
        access(1'b1, 12'h408, 32'h0);
        expect32("R1 mux default restored", bus_rdata, 32'h0601);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule